// File: doc/BRIEF.md
# Grouped DMA Event Interrupt Register

This block is a single 32-bit control and status word for a DMA bridge that raises ten kinds of transfer event. One USB engine and two audio channels, each with a playback and a record direction, produce the events. Each event has a sticky status flag, which is set by a one-cycle pulse, and an enable flag. Both flags live in the same word.

Software reads the word, writes it back to change enables, and acknowledges an event by writing a zero to its status position. Enabled, pending events are merged by category onto three level interrupt lines:

- one line for the USB address error;
- one line for the completion events;
- one line for the audio half-buffer events.

Top module: `dma_evt_irq_reg`

## Requirements
- R1: After reset every bit of `rd_data` reads 0 and all three `irq` lines are low.
- R2: A pulse on `evt_pulse[n]` sets the status flag of event n from the next cycle, whether or not it is enabled. The status flag of event n sits at bit n for n = 0 or 1, and at bit 14+n for n = 2..9.
- R3: A status flag stays set through idle cycles, and writing 1 to a status position has no effect.
- R4: A write with 0 at an event's status position clears that flag from the next cycle.
- R5: If an event pulse and a clearing write hit the same flag in one cycle, the flag ends set.
- R6: Every write loads each enable flag from its own bit: bit 8 for event 0, bit 9 for event 1, and bit 22+n for event n = 2..9. Enables hold when no write occurs.
- R7: `irq[0]` is high exactly when event 1 (USB address error) is both pending and enabled.
- R8: `irq[1]` is high when any of events 0, 2, 4, 6 or 8 (USB transfer done and the four audio full-buffer events) is pending and enabled.
- R9: `irq[2]` is high when any of events 3, 5, 7 or 9 (the four audio half-buffer events) is pending and enabled.
- R10: Bits 15..10 and 7..2 always read 0, and writes to them are ignored.
- R11: Writing back the current enable bits with every status position at 0 clears all pending flags in one cycle and leaves every enable unchanged.
- R12: A masked pending event shows in `rd_data` but drives no line. Enabling it later raises its line in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Write value |
| rd_data | output | 32 | Current register contents |
| evt_pulse | input | 10 | One-cycle event pulses, index = event number |
| irq | output | 3 | Level interrupt lines by category |

## Verification
Two functions can fall in the same cycle: an event pulse arriving on a flag, and a software write that clears that flag. The bench provokes this by driving a pulse together with a zero-status write, both on single events and across all ten events at once. The result is judged against a model in which the set wins. The same collision is also applied to the read-modify-write acknowledge, to confirm that pulses landing on that cycle survive while all other flags clear and the enables stay as they were.

// File: rtl/evt_reg_pkg.sv
package evt_reg_pkg;
  localparam int NUM_EVT  = 10;
  localparam int NUM_LINE = 3;
  localparam int REG_W    = 32;
  localparam int USB_EVT  = 2;
  localparam int AUD_STAT_BASE = 14;
  localparam int AUD_EN_BASE   = 22;
  localparam int USB_EN_BASE   = 8;

  typedef enum logic [1:0] {
    LINE_ADDR_ERR = 2'd0,
    LINE_DONE     = 2'd1,
    LINE_HALF     = 2'd2
  } line_e;

  // bit position of the status flag of an event
  function automatic int stat_bit(input int idx);
    return (idx < USB_EVT) ? idx : AUD_STAT_BASE + idx;
  endfunction

  // bit position of the enable flag of an event
  function automatic int en_bit(input int idx);
    return (idx < USB_EVT) ? USB_EN_BASE + idx : AUD_EN_BASE + idx;
  endfunction

  // category line an event is merged onto
  function automatic line_e evt_line(input int idx);
    if (idx == 1)       return LINE_ADDR_ERR;
    if (idx == 0)       return LINE_DONE;
    if ((idx % 2) == 0) return LINE_DONE;
    return LINE_HALF;
  endfunction
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] stat_wd,
  input  logic [N-1:0] pulse,
  output logic [N-1:0] status
);
  logic [N-1:0] clr_evt;
  logic [N-1:0] set_evt;

  assign set_evt = pulse;
  assign clr_evt = wr_en ? ~stat_wd : '0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rst_n)          status[g] <= 1'b0;
        else if (set_evt[g]) status[g] <= 1'b1;
        else if (clr_evt[g]) status[g] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/evt_enable_bank.sv
module evt_enable_bank #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] en_wd,
  output logic [N-1:0] enable
);
  always_ff @(posedge clk) begin
    if (!rst_n)     enable <= '0;
    else if (wr_en) enable <= en_wd;
  end
endmodule

// File: rtl/evt_line_merge.sv
module evt_line_merge
  import evt_reg_pkg::*;
#(
  parameter int N = 10,
  parameter int L = 3
) (
  input  logic [N-1:0] status,
  input  logic [N-1:0] enable,
  output logic [L-1:0] irq
);
  logic [N-1:0] active;
  assign active = status & enable;

  genvar l;
  generate
    for (l = 0; l < L; l++) begin : g_line
      always_comb begin
        irq[l] = 1'b0;
        for (int i = 0; i < N; i++) begin
          if (int'(evt_line(i)) == l) irq[l] = irq[l] | active[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/dma_evt_irq_reg.sv
module dma_evt_irq_reg
  import evt_reg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  input  logic [NUM_EVT-1:0]  evt_pulse,
  output logic [NUM_LINE-1:0] irq
);
  logic [NUM_EVT-1:0] stat_wd;
  logic [NUM_EVT-1:0] en_wd;
  logic [NUM_EVT-1:0] status;
  logic [NUM_EVT-1:0] enable;

  genvar g;
  generate
    for (g = 0; g < NUM_EVT; g++) begin : g_unpack
      assign stat_wd[g] = wr_data[stat_bit(g)];
      assign en_wd[g]   = wr_data[en_bit(g)];
    end
  endgenerate

  evt_status_bank #(.N(NUM_EVT)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .stat_wd(stat_wd), .pulse(evt_pulse), .status(status)
  );

  evt_enable_bank #(.N(NUM_EVT)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .en_wd(en_wd), .enable(enable)
  );

  evt_line_merge #(.N(NUM_EVT), .L(NUM_LINE)) u_merge (
    .status(status), .enable(enable), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      rd_data[stat_bit(i)] = status[i];
      rd_data[en_bit(i)]   = enable[i];
    end
  end
endmodule

// File: rtl/dma_evt_irq_reg_chk.sv
module dma_evt_irq_reg_chk
  import evt_reg_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [REG_W-1:0]    wr_data,
  input logic [REG_W-1:0]    rd_data,
  input logic [NUM_EVT-1:0]  evt_pulse,
  input logic [NUM_LINE-1:0] irq,
  input logic [NUM_EVT-1:0]  status,
  input logic [NUM_EVT-1:0]  enable
);
  genvar g;
  generate
    for (g = 0; g < NUM_EVT; g++) begin : g_evt
      localparam int SB = stat_bit(g);
      localparam int EB = en_bit(g);
      a_r2_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse[g] |=> rd_data[SB]);
      a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[g] && !(wr_en && !wr_data[SB])) |=> rd_data[SB]);
      a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[SB] && !evt_pulse[g]) |=> !rd_data[SB]);
      a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[EB] == $past(wr_data[EB])));
      a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(enable[g]));
    end
  endgenerate

  a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15:10] == 6'd0) && (rd_data[7:2] == 6'd0));
  a_r7_addr_err_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] == (rd_data[1] && rd_data[9]));
  a_r9_half_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq[2] |-> ((rd_data[31:24] & rd_data[23:16] & 8'hAA) != 8'd0));
  a_r8_done_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq[1] |-> ((rd_data[0] && rd_data[8]) ||
                ((rd_data[31:24] & rd_data[23:16] & 8'h55) != 8'd0)));
endmodule

bind dma_evt_irq_reg dma_evt_irq_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .evt_pulse(evt_pulse), .irq(irq),
  .status(status), .enable(enable)
);

// File: tb/sim_dma_evt_irq_reg.sv
`timescale 1ns/1ps
module sim_dma_evt_irq_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [9:0]  evt_pulse = '0;
  logic [2:0]  irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] rd;
    logic [2:0]  ln;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  logic [31:0] m = '0;

  always #2.5 clk = ~clk;

  dma_evt_irq_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .evt_pulse(evt_pulse), .irq(irq)
  );

  localparam logic [31:0] ST_MASK = 32'h00FF_0003;
  localparam logic [31:0] EN_MASK = 32'hFF00_0300;

  function automatic int spos(int n);
    case (n)
      0: return 0;
      1: return 1;
      default: return n + 14;
    endcase
  endfunction

  function automatic logic [2:0] lines(logic [31:0] r);
    logic [7:0] a;
    a = r[23:16] & r[31:24];
    lines[0] = r[1] & r[9];
    lines[1] = (r[0] & r[8]) | a[0] | a[2] | a[4] | a[6];
    lines[2] = a[1] | a[3] | a[5] | a[7];
  endfunction

  // driver: applies one cycle and pushes expected result
  task automatic step(bit wr, logic [31:0] wd, logic [9:0] p, string tag);
    logic [31:0] n;
    exp_t e;
    @(negedge clk);
    wr_en = wr; wr_data = wd; evt_pulse = p;
    n = m;
    if (wr) begin
      n = (n & ~EN_MASK) | (wd & EN_MASK);
      n = n & (wd | ~ST_MASK);
    end
    for (int i = 0; i < 10; i++) if (p[i]) n[spos(i)] = 1'b1;
    m = n;
    e.rd = n; e.ln = lines(n); e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compares after each edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() != 0) begin
      exp_t e;
      e = sb_q.pop_front();
      tests++;
      if (rd_data !== e.rd || irq !== e.ln) begin
        fails++;
        $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b",
                 e.tag, rd_data, irq, e.rd, e.ln);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #0.5;
    tests++;
    if (rd_data !== 32'd0 || irq !== 3'd0) begin
      fails++;
      $display("FAIL R1: rd=%h irq=%b expected rd=0 irq=000", rd_data, irq);
    end
    // R2: each event alone, all masked
    for (int i = 0; i < 10; i++) step(1'b0, '0, 10'(1 << i), "R2 set");
    step(1'b0, '0, '0, "R3 idle hold");
    // R4: clear all, R10 unused writes ignored
    step(1'b1, 32'h0000_FCFC, '0, "R4 R10 clear/unused");
    // R10/R6: all ones: enables on, status writes of 1 no effect
    step(1'b1, 32'hFFFF_FFFF, '0, "R3 R6 R10 ones");
    // R7 R8 R9 individual lines
    step(1'b0, '0, 10'b00_0000_0010, "R7 addr err line");
    step(1'b1, 32'hFFFF_FFFD, '0, "R4 clear ev1");
    step(1'b0, '0, 10'b00_0000_0001, "R8 usb done line");
    step(1'b1, 32'hFFFF_FFFE, 10'b00_0000_0100, "R5 R8 audio full");
    step(1'b1, 32'hFF00_0300, '0, "R11 rmw clear");
    step(1'b0, '0, 10'b00_0000_1000, "R9 half line");
    step(1'b0, '0, 10'b10_0000_0000, "R9 ch1 rec half");
    step(1'b1, 32'hFF00_0300, 10'b10_0000_0000, "R5 R11 collide");
    step(1'b1, 32'hFF00_0300, '0, "R11 rmw clear");
    // R12 masked pending
    step(1'b1, 32'h0000_0000, '0, "R6 mask all");
    step(1'b0, '0, 10'b11_1111_1111, "R12 masked pend");
    step(1'b1, 32'h00FF_0003, '0, "R3 write ones status");
    step(1'b1, 32'h4000_0003, '0, "R12 enable ev8");
    step(1'b1, 32'h40FF_0203, '0, "R12 R7 enable ev1");
    step(1'b1, 32'h0000_0000, 10'b11_1111_1111, "R5 all collide");
    step(1'b1, 32'hFFFF_0303, '0, "R8 R9 all on");
    step(1'b1, 32'hFF00_0300, '0, "R11 rmw all");
    step(1'b0, '0, '0, "R3 idle");
    @(negedge clk); wr_en = 1'b0; evt_pulse = '0;
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: rd=%h irq=%b expected completion", rd_data, irq);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule